// File: doc/BRIEF.md
# Key-guarded countdown watchdog

This block is a watchdog timer for a chip's control processor. A register bus with 16-bit data programs a timeout in units of a slow tick, and the block counts down once per tick strobe. Software keeps the system alive by writing a fixed magic word to the feed register. If the count runs out, the block raises a reset pulse and records a timed-out status that survives until software clears it. One tick before expiry it raises a warning event. That event, together with a force bit, is gated by a mask onto an interrupt line.

Each action that changes the timer's state needs an exact 16-bit key word. Feeding, clearing the status and resuming each need one key. Disabling needs two keys written in sequence to two registers. A write with any other value has no effect, so a runaway program that scribbles over the register space is unlikely to silence the watchdog. Status and enable state read back as multi-bit code words instead of single bits. The count register carries a flag that warns software the count is about to change. A debug-mode input stops the count unless software has set an override bit.

Top module: `wdk_top`

## Requirements
- R1: After reset the timer is enabled and the count and timeout equal the default timeout (6000). Reads at 0x0C and 0x10 return 0x0000, and irq and wd_reset are low.
- R2: Writing 0xFEED to offset 0x00 loads the count from the timeout register at the next clock edge. Any other value written there leaves the count unchanged. Offset 0x00 reads 0x0000.
- R3: Offset 0x04 holds a 15-bit timeout. A write stores wdata & 0x7FFF, and a read returns the stored value.
- R4: While enabled, each tick decrements the count by one. When debug_mode is high, the count moves only if override bit 0 at 0x18 is set. A read at 0x14 returns the count in bits 14:0. Bit 15 is 1 in a cycle where the count will change at the next edge, and 0 otherwise.
- R5: A counting tick with the count at 1 or 0 is an expiry. On expiry, wd_reset is high for the single following cycle, the count reloads from the timeout, and offset 0x10 reads 0xCFE8. A feed key in the same cycle as that tick wins: the count reloads and no pulse occurs.
- R6: Writing 0xE8B4 to 0x10 returns its read value to 0x0000. Other values have no effect. An expiry in the same cycle as the clear leaves it at 0xCFE8.
- R7: Writing 0x2BAD to 0x08 arms a disable, and a following write of 0xCAFE to 0x0C disables the timer. Any write to 0x0C disarms. So a 0x0C write without a preceding arm, or with a wrong value, leaves the timer enabled. Offset 0x0C reads 0xDABE while disabled and 0x0000 while enabled. A disabled timer neither counts nor pulses.
- R8: Writing 0xACED to 0x1C while disabled re-enables the timer and loads the count from the timeout. Other values have no effect.
- R9: Bit 0 at 0x20 is the warning event. It is set by a counting tick that takes the count from 2 to 1, and cleared by a write with bit 0 set. A set in the same cycle as a clear wins.
- R10: irq is high when (event OR force) AND mask. The mask is bit 0 at 0x24 and force is bit 0 at 0x28. Both read back in bit 0.
- R11: A read at 0x18 returns debug_mode in bit 1 and the override in bit 0. A write sets the override from wdata bit 0.
- R12: Reads of 0x08, 0x1C and any unmapped offset return 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe marking each timeout unit |
| debug_mode | input | 1 | High while an external debugger holds the system |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the current state |
| irq | output | 1 | Masked warning interrupt |
| wd_reset | output | 1 | One-cycle system reset request on expiry |

## Verification
Two pairs of events are forced into the same cycle: the expiring tick with a feed key, and the expiring tick with a status-clear key. For the first pair, the count is ticked down to 1 and the feed is issued together with the final tick. This must reload the count and leave wd_reset low. For the second pair, the status clear is issued with the final tick. The pulse must still appear and the status must still read 0xCFE8. Random traffic repeats both collisions and the warning-set versus acknowledge collision, and a cycle-level model of the requirements judges each one.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int CNT_W = 15;
  localparam int DATA_W = 16;

  localparam logic [7:0] OFS_FEED   = 8'h00;
  localparam logic [7:0] OFS_TMO    = 8'h04;
  localparam logic [7:0] OFS_DIS1   = 8'h08;
  localparam logic [7:0] OFS_DIS2   = 8'h0C;
  localparam logic [7:0] OFS_STAT   = 8'h10;
  localparam logic [7:0] OFS_CNT    = 8'h14;
  localparam logic [7:0] OFS_DBG    = 8'h18;
  localparam logic [7:0] OFS_RESUME = 8'h1C;
  localparam logic [7:0] OFS_EVT    = 8'h20;
  localparam logic [7:0] OFS_MASK   = 8'h24;
  localparam logic [7:0] OFS_FORCE  = 8'h28;

  localparam logic [DATA_W-1:0] KEY_FEED    = 16'hFEED;
  localparam logic [DATA_W-1:0] KEY_ARM     = 16'h2BAD;
  localparam logic [DATA_W-1:0] KEY_OFF     = 16'hCAFE;
  localparam logic [DATA_W-1:0] KEY_RESUME  = 16'hACED;
  localparam logic [DATA_W-1:0] KEY_CLEAR   = 16'hE8B4;
  localparam logic [DATA_W-1:0] CODE_OFF    = 16'hDABE;
  localparam logic [DATA_W-1:0] CODE_EXPIRED = 16'hCFE8;

  typedef struct packed {
    logic feed;
    logic tmo_wr;
    logic arm_wr;
    logic arm_key;
    logic off_wr;
    logic off_key;
    logic resume_key;
    logic clear_key;
    logic dbg_wr;
    logic ack;
    logic mask_wr;
    logic force_wr;
  } wdk_cmd_t;
endpackage

// File: rtl/wdk_decode.sv
module wdk_decode
  import wdk_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output wdk_cmd_t          cmd
);
  logic wen;

  always_comb begin
    wen            = bus_sel && bus_wr;
    cmd.feed       = wen && (bus_addr == ADDR_W'(OFS_FEED)) && (bus_wdata == KEY_FEED);
    cmd.tmo_wr     = wen && (bus_addr == ADDR_W'(OFS_TMO));
    cmd.arm_wr     = wen && (bus_addr == ADDR_W'(OFS_DIS1));
    cmd.arm_key    = (bus_wdata == KEY_ARM);
    cmd.off_wr     = wen && (bus_addr == ADDR_W'(OFS_DIS2));
    cmd.off_key    = (bus_wdata == KEY_OFF);
    cmd.resume_key = wen && (bus_addr == ADDR_W'(OFS_RESUME)) && (bus_wdata == KEY_RESUME);
    cmd.clear_key  = wen && (bus_addr == ADDR_W'(OFS_STAT)) && (bus_wdata == KEY_CLEAR);
    cmd.dbg_wr     = wen && (bus_addr == ADDR_W'(OFS_DBG));
    cmd.ack        = wen && (bus_addr == ADDR_W'(OFS_EVT)) && bus_wdata[0];
    cmd.mask_wr    = wen && (bus_addr == ADDR_W'(OFS_MASK));
    cmd.force_wr   = wen && (bus_addr == ADDR_W'(OFS_FORCE));
  end
endmodule

// File: rtl/wdk_ctrl.sv
module wdk_ctrl
  import wdk_pkg::*;
#(
  parameter int DEF_TMO = 6000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wdk_cmd_t         cmd,
  input  logic [CNT_W-1:0] tmo_data,
  input  logic             wbit0,
  input  logic             expire,
  output logic             enabled,
  output logic             armed,
  output logic             timed_out,
  output logic             dbg_run,
  output logic [CNT_W-1:0] tmo
);
  logic en_d, arm_d, to_d;

  always_comb begin
    en_d = enabled;
    if (cmd.off_wr && armed && cmd.off_key) en_d = 1'b0;
    else if (cmd.resume_key)                en_d = 1'b1;

    arm_d = armed;
    if (cmd.arm_wr)      arm_d = cmd.arm_key;
    else if (cmd.off_wr) arm_d = 1'b0;

    to_d = timed_out;
    if (expire)             to_d = 1'b1;
    else if (cmd.clear_key) to_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled   <= 1'b1;
      armed     <= 1'b0;
      timed_out <= 1'b0;
      dbg_run   <= 1'b0;
      tmo       <= CNT_W'(DEF_TMO);
    end else begin
      enabled   <= en_d;
      armed     <= arm_d;
      timed_out <= to_d;
      if (cmd.dbg_wr) dbg_run <= wbit0;
      if (cmd.tmo_wr) tmo     <= tmo_data;
    end
  end
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter
  import wdk_pkg::*;
#(
  parameter int DEF_TMO = 6000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             debug_mode,
  input  logic             enabled,
  input  logic             dbg_run,
  input  logic             sw_reload,
  input  logic [CNT_W-1:0] tmo,
  output logic [CNT_W-1:0] count,
  output logic             changing,
  output logic             expire,
  output logic             warn,
  output logic             wd_reset
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic             tick_ok;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    tick_ok  = tick && enabled && (!debug_mode || dbg_run);
    changing = tick_ok || sw_reload;
    expire   = tick_ok && !sw_reload && (count <= ONE);
    warn     = tick_ok && !sw_reload && (count == TWO);
    if (sw_reload || expire) cnt_d = tmo;
    else                     cnt_d = count - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= CNT_W'(DEF_TMO);
      wd_reset <= 1'b0;
    end else begin
      if (changing) count <= cnt_d;
      wd_reset <= expire;
    end
  end
endmodule

// File: rtl/wdk_irq.sv
module wdk_irq
  import wdk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     warn,
  input  wdk_cmd_t cmd,
  input  logic     wbit0,
  output logic     evt,
  output logic     msk,
  output logic     frc,
  output logic     irq
);
  logic evt_d;

  always_comb begin
    evt_d = evt;
    if (warn)         evt_d = 1'b1;
    else if (cmd.ack) evt_d = 1'b0;
    irq = (evt | frc) & msk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt <= 1'b0;
      msk <= 1'b0;
      frc <= 1'b0;
    end else begin
      evt <= evt_d;
      if (cmd.mask_wr)  msk <= wbit0;
      if (cmd.force_wr) frc <= wbit0;
    end
  end
endmodule

// File: rtl/wdk_top.sv
module wdk_top
  import wdk_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DEF_TMO = 6000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              debug_mode,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq,
  output logic              wd_reset
);
  wdk_cmd_t         cmd;
  logic             enabled, armed, timed_out, dbg_run;
  logic [CNT_W-1:0] tmo, count;
  logic             changing, expire, warn, sw_reload;
  logic             evt, msk, frc;

  wdk_decode #(.ADDR_W(ADDR_W)) i_decode (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cmd(cmd)
  );

  wdk_ctrl #(.DEF_TMO(DEF_TMO)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .tmo_data(bus_wdata[CNT_W-1:0]),
    .wbit0(bus_wdata[0]), .expire(expire), .enabled(enabled), .armed(armed),
    .timed_out(timed_out), .dbg_run(dbg_run), .tmo(tmo)
  );

  assign sw_reload = cmd.feed | (cmd.resume_key & ~enabled);

  wdk_counter #(.DEF_TMO(DEF_TMO)) i_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .debug_mode(debug_mode),
    .enabled(enabled), .dbg_run(dbg_run), .sw_reload(sw_reload), .tmo(tmo),
    .count(count), .changing(changing), .expire(expire), .warn(warn),
    .wd_reset(wd_reset)
  );

  wdk_irq i_irq (
    .clk(clk), .rst_n(rst_n), .warn(warn), .cmd(cmd), .wbit0(bus_wdata[0]),
    .evt(evt), .msk(msk), .frc(frc), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_TMO))        bus_rdata = {1'b0, tmo};
    else if (bus_addr == ADDR_W'(OFS_DIS2))  bus_rdata = enabled ? 16'h0000 : CODE_OFF;
    else if (bus_addr == ADDR_W'(OFS_STAT))  bus_rdata = timed_out ? CODE_EXPIRED : 16'h0000;
    else if (bus_addr == ADDR_W'(OFS_CNT))   bus_rdata = {changing, count};
    else if (bus_addr == ADDR_W'(OFS_DBG))   bus_rdata = {14'd0, debug_mode, dbg_run};
    else if (bus_addr == ADDR_W'(OFS_EVT))   bus_rdata = {15'd0, evt};
    else if (bus_addr == ADDR_W'(OFS_MASK))  bus_rdata = {15'd0, msk};
    else if (bus_addr == ADDR_W'(OFS_FORCE)) bus_rdata = {15'd0, frc};
  end
endmodule

// File: rtl/wdk_check.sv
module wdk_check
  import wdk_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic              enabled,
  input logic              armed,
  input logic              timed_out,
  input logic [CNT_W-1:0]  count,
  input logic              irq,
  input logic              wd_reset
);
  logic wen;
  assign wen = bus_sel && bus_wr;

  a_r5_pulse_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |-> timed_out);

  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> !wd_reset);

  a_r7_no_off_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && !armed && wen && bus_addr == ADDR_W'(OFS_DIS2)) |=> enabled);

  a_r7_off_with_keys: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wen && bus_addr == ADDR_W'(OFS_DIS2) && bus_wdata == KEY_OFF) |=> !enabled);

  a_r2_bad_feed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && bus_addr == ADDR_W'(OFS_FEED) && bus_wdata != KEY_FEED && !tick) |=> $stable(count));

  a_r10_mask_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && bus_addr == ADDR_W'(OFS_MASK) && !bus_wdata[0]) |=> !irq);
endmodule

bind wdk_top wdk_check #(.ADDR_W(ADDR_W)) i_check (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .enabled(enabled), .armed(armed),
  .timed_out(timed_out), .count(count), .irq(irq), .wd_reset(wd_reset)
);

// File: tb/test_wdk_top.sv
module test_wdk_top;
  logic        clk, rst_n, tick, dbg, sel, wr;
  logic [5:0]  addr;
  logic [15:0] wdata, rdata;
  logic        irq, wd_reset;
  int n_chk, n_fail;

  // bench model of the requirements
  logic        m_en, m_arm, m_stat, m_drun, m_evt, m_msk, m_frc, m_rst;
  logic [14:0] m_tmo, m_cnt;

  wdk_top #(.ADDR_W(6), .DEF_TMO(6000)) i_wdk_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .debug_mode(dbg), .bus_sel(sel),
    .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .irq(irq), .wd_reset(wd_reset)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [5:0] a);
    case (a)
      6'h04: return "R3";
      6'h0C: return "R7";
      6'h10: return "R6";
      6'h14: return "R4";
      6'h18: return "R11";
      6'h20: return "R9";
      6'h24, 6'h28: return "R10";
      default: return "R12";
    endcase
  endfunction

  function automatic logic tick_ok_f(input logic t);
    return t && m_en && (!dbg || m_drun);
  endfunction

  function automatic logic [15:0] model_read(input logic [5:0] a, input logic t);
    case (a)
      6'h04: return {1'b0, m_tmo};
      6'h0C: return m_en ? 16'h0000 : 16'hDABE;
      6'h10: return m_stat ? 16'hCFE8 : 16'h0000;
      6'h14: return {tick_ok_f(t), m_cnt};
      6'h18: return {14'd0, dbg, m_drun};
      6'h20: return {15'd0, m_evt};
      6'h24: return {15'd0, m_msk};
      6'h28: return {15'd0, m_frc};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic step(input logic s, input logic w, input logic [5:0] a,
                      input logic [15:0] d, input logic t, output logic [15:0] rv);
    logic hit, feed, resume, tok, rel, exp_e, warn_e;
    logic n_en, n_arm, n_stat, n_drun, n_evt, n_msk, n_frc;
    logic [14:0] n_tmo, n_cnt;
    @(negedge clk);
    sel = s; wr = w; addr = a; wdata = d; tick = t;
    #1;
    rv = rdata;
    if (s && !w) chk(tag_of(a), rdata, model_read(a, t));
    hit    = s && w;
    feed   = hit && a == 6'h00 && d == 16'hFEED;
    resume = hit && a == 6'h1C && d == 16'hACED && !m_en;
    tok    = tick_ok_f(t);
    rel    = feed || resume;
    exp_e  = tok && !rel && m_cnt <= 15'd1;
    warn_e = tok && !rel && m_cnt == 15'd2;
    n_cnt  = rel ? m_tmo : (tok ? ((m_cnt <= 15'd1) ? m_tmo : m_cnt - 15'd1) : m_cnt);
    n_tmo  = (hit && a == 6'h04) ? d[14:0] : m_tmo;
    n_arm  = (hit && a == 6'h08) ? (d == 16'h2BAD) : ((hit && a == 6'h0C) ? 1'b0 : m_arm);
    n_en   = (hit && a == 6'h0C && m_arm && d == 16'hCAFE) ? 1'b0 : (resume ? 1'b1 : m_en);
    n_stat = exp_e ? 1'b1 : ((hit && a == 6'h10 && d == 16'hE8B4) ? 1'b0 : m_stat);
    n_evt  = warn_e ? 1'b1 : ((hit && a == 6'h20 && d[0]) ? 1'b0 : m_evt);
    n_msk  = (hit && a == 6'h24) ? d[0] : m_msk;
    n_frc  = (hit && a == 6'h28) ? d[0] : m_frc;
    n_drun = (hit && a == 6'h18) ? d[0] : m_drun;
    @(posedge clk);
    m_cnt = n_cnt; m_tmo = n_tmo; m_arm = n_arm; m_en = n_en; m_stat = n_stat;
    m_evt = n_evt; m_msk = n_msk; m_frc = n_frc; m_drun = n_drun; m_rst = exp_e;
    #1;
    chk("R5", {15'd0, wd_reset}, {15'd0, m_rst});
    chk("R10", {15'd0, irq}, {15'd0, (m_evt | m_frc) & m_msk});
  endtask

  task automatic rd(input logic [5:0] a, input string tag, input logic [15:0] exp, input logic t = 1'b0);
    logic [15:0] rv;
    step(1'b1, 1'b0, a, 16'h0, t, rv);
    chk(tag, rv, exp);
  endtask

  task automatic wrt(input logic [5:0] a, input logic [15:0] d, input logic t = 1'b0);
    logic [15:0] rv;
    step(1'b1, 1'b1, a, d, t, rv);
  endtask

  task automatic tk(input int n);
    logic [15:0] rv;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 6'h00, 16'h0, 1'b1, rv);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] rv;
    void'($urandom(32'd4242));
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; tick = 1'b0; dbg = 1'b0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    m_en = 1'b1; m_arm = 1'b0; m_stat = 1'b0; m_drun = 1'b0; m_evt = 1'b0;
    m_msk = 1'b0; m_frc = 1'b0; m_rst = 1'b0; m_tmo = 15'd6000; m_cnt = 15'd6000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", {15'd0, wd_reset}, 16'h0);
    chk("R1", {15'd0, irq}, 16'h0);
    rd(6'h0C, "R1", 16'h0000);
    rd(6'h10, "R1", 16'h0000);
    rd(6'h14, "R1", 16'd6000);
    rd(6'h04, "R1", 16'd6000);
    // R3 timeout register
    wrt(6'h04, 16'd5);  rd(6'h04, "R3", 16'd5);
    wrt(6'h04, 16'hFFFF); rd(6'h04, "R3", 16'h7FFF);
    wrt(6'h04, 16'd5);
    // R2 feed key and a wrong feed value
    wrt(6'h00, 16'hFEED); rd(6'h14, "R2", 16'd5);
    tk(2);
    wrt(6'h00, 16'h1234); rd(6'h14, "R2", 16'd3);
    rd(6'h00, "R2", 16'h0000);
    // R4 change flag while ticking
    rd(6'h14, "R4", 16'h8003, 1'b1);
    tk(1);
    rd(6'h20, "R9", 16'h0001);
    // R5 expiry
    tk(1);
    chk("R5", {15'd0, wd_reset}, 16'h1);
    step(1'b0, 1'b0, 6'h00, 16'h0, 1'b0, rv);
    chk("R5", {15'd0, wd_reset}, 16'h0);
    rd(6'h10, "R5", 16'hCFE8);
    rd(6'h14, "R5", 16'd5);
    // R10 mask / force, R9 acknowledge
    wrt(6'h24, 16'h1); chk("R10", {15'd0, irq}, 16'h1);
    wrt(6'h20, 16'h1); chk("R9", {15'd0, irq}, 16'h0);
    rd(6'h20, "R9", 16'h0);
    wrt(6'h28, 16'h1); chk("R10", {15'd0, irq}, 16'h1);
    wrt(6'h28, 16'h0); chk("R10", {15'd0, irq}, 16'h0);
    // R6 status clear
    wrt(6'h10, 16'h1111); rd(6'h10, "R6", 16'hCFE8);
    wrt(6'h10, 16'hE8B4); rd(6'h10, "R6", 16'h0000);
    // R5 feed with expiring tick: feed wins
    tk(4);
    wrt(6'h00, 16'hFEED, 1'b1);
    chk("R5", {15'd0, wd_reset}, 16'h0);
    rd(6'h14, "R5", 16'd5);
    // R6 clear with expiring tick: set wins
    tk(4);
    wrt(6'h10, 16'hE8B4, 1'b1);
    chk("R5", {15'd0, wd_reset}, 16'h1);
    rd(6'h10, "R6", 16'hCFE8);
    wrt(6'h10, 16'hE8B4);
    wrt(6'h20, 16'h1);
    // R7 disable sequence
    wrt(6'h0C, 16'hCAFE); rd(6'h0C, "R7", 16'h0000);
    wrt(6'h08, 16'h2BAD); wrt(6'h0C, 16'h1234); rd(6'h0C, "R7", 16'h0000);
    wrt(6'h0C, 16'hCAFE); rd(6'h0C, "R7", 16'h0000);
    wrt(6'h08, 16'h2BAD); wrt(6'h0C, 16'hCAFE); rd(6'h0C, "R7", 16'hDABE);
    tk(3);
    rd(6'h14, "R7", 16'd5);
    // R8 resume
    wrt(6'h04, 16'd7);
    wrt(6'h1C, 16'h1111); rd(6'h0C, "R8", 16'hDABE);
    wrt(6'h1C, 16'hACED); rd(6'h0C, "R8", 16'h0000);
    rd(6'h14, "R8", 16'd7);
    rd(6'h08, "R12", 16'h0000);
    rd(6'h1C, "R12", 16'h0000);
    // R11 debug mode and override
    dbg = 1'b1;
    rd(6'h18, "R11", 16'h0002);
    tk(1); rd(6'h14, "R4", 16'd7);
    wrt(6'h18, 16'h1); rd(6'h18, "R11", 16'h0003);
    tk(1); rd(6'h14, "R4", 16'd6);
    wrt(6'h18, 16'h0);
    dbg = 1'b0;
    // R12 unmapped
    rd(6'h3C, "R12", 16'h0000);
    // constrained random traffic checked against the model
    for (int i = 0; i < 4000; i++) begin
      logic [5:0]  a;
      logic [15:0] d;
      logic        s, w, t;
      int          k;
      k = int'($urandom_range(0, 12));
      a = (k == 12) ? 6'h30 : 6'(k * 4);
      s = ($urandom_range(0, 9) < 7);
      w = ($urandom_range(0, 9) < 5);
      t = ($urandom_range(0, 2) == 0);
      d = 16'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        case (a)
          6'h00: d = 16'hFEED;
          6'h08: d = 16'h2BAD;
          6'h0C: d = 16'hCAFE;
          6'h10: d = 16'hE8B4;
          6'h1C: d = 16'hACED;
          default: d = 16'($urandom_range(0, 1));
        endcase
      end
      if (a == 6'h04) d = 16'($urandom_range(0, 9));
      if ($urandom_range(0, 49) == 0) dbg = ~dbg;
      step(s, w, a, d, t, rv);
    end
    summary();
    $finish;
  end
endmodule